// File: doc/BRIEF.md
# Stack Pointer and Push/Pop Sequencer

This block keeps a 16-bit stack pointer and turns push and pop requests of one, two or three bytes into a series of byte-wide accesses on a synchronous memory port. Each access takes one cycle. A request is taken through a valid/ready handshake. While a sequence runs, the unit accepts nothing else. When the sequence is complete, a one-cycle done pulse is raised. A pop collects the bytes it reads into a right-aligned result word.

A push writes first and then moves the pointer down. A pop moves the pointer up first and then reads. In emulation mode every pointer update, including a direct load, keeps the pointer's upper byte at 0x01. The lower byte then wraps around inside that page. Multi-byte values go onto the stack most significant byte first, so they come back off least significant byte first. A direct load input lets the surrounding control logic overwrite the pointer whenever no sequence is running.

Top module: `stack_ptr_unit`

## Requirements
- R1: A push byte is written at the current pointer address, and the pointer then decrements by one, wrapping modulo 2^16 in native mode.
- R2: A pop byte first increments the pointer and then reads at the incremented address. The read data comes back on mem_rdata in the following cycle.
- R3: When emu_mode is 1, every pointer step gives {0x01, low byte}. A push from 0x0100 therefore leads to 0x01FF, and a pop from 0x01FF reads 0x0100.
- R4: req_data holds the low byte in [7:0], the high byte in [15:8] and the bank byte in [23:16]. A 2-byte push writes the high byte and then the low byte. A 3-byte push writes the bank byte, then the high byte, then the low byte.
- R5: A pop places the first byte read in pop_data[7:0], the second in [15:8] and the third in [23:16]. Lanes that are not read stay at zero. pop_data is cleared when a pop is accepted, and it holds its value until the next pop is accepted.
- R6: load_en in an idle cycle sets the pointer to load_value. In emulation mode the upper byte is forced to 0x01. load_en while a sequence is running is ignored.
- R7: mem_addr[23:16] is zero on every access. mem_wr_en and mem_rd_en are never high together.
- R8: req_ready is high only when the unit is idle. A request is accepted when req_valid and req_ready are both high. A request of size 0 is ignored and causes no access and no done. The byte accesses take the N consecutive cycles that follow acceptance.
- R9: done is high for exactly one cycle. For a push, done comes in the cycle after the last write. For a pop, done comes in the cycle after the last byte returns, so that is N+1 cycles after acceptance for a push and N+2 for a pop.
- R10: After reset the pointer is 0x01FF, req_ready is 1, done is 0, no access is made, and pop_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_mode | input | 1 | Confine the pointer to page 0x01 |
| load_en | input | 1 | Overwrite the pointer (idle only) |
| load_value | input | 16 | Value for a direct load |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_push | input | 1 | 1 = push, 0 = pop |
| req_size | input | 2 | Byte count 1..3 |
| req_data | input | 24 | Value to push |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 24 | Assembled popped value |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 24 | Byte address, bank zero |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rd_en | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read byte, one cycle after mem_rd_en |

## Verification
A wrong byte counter or lane index shows up in the same sequence. Either done arrives at a different cycle from the acceptance edge, or the bytes land at the wrong addresses or in the wrong lanes. The table pairs each push with a later pop of the same value, so any byte-order fault shows in pop_data as soon as that pop's done arrives. A missing page-one clamp shows on mem_addr at the first step that wraps the low byte. A load that leaks into a running sequence moves the address of the very next byte access.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2
  } stk_state_e;

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned SP_W = 16,
  parameter int unsigned LOW_W = 8,
  parameter logic [SP_W-1:0] RESET_SP = 16'h01FF,
  parameter logic [SP_W-LOW_W-1:0] EMU_PAGE = 'h1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emu,
  input  logic            load,
  input  logic [SP_W-1:0] load_value,
  input  logic            step,
  input  logic            step_up,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_up
);

  logic [SP_W-1:0] sp_dn;
  logic [SP_W-1:0] sp_d;
  logic            sp_en;

  function automatic logic [SP_W-1:0] confine(input logic [SP_W-1:0] v, input logic e);
    return e ? {EMU_PAGE, v[LOW_W-1:0]} : v;
  endfunction

  always_comb begin
    sp_up = confine(sp_q + 1'b1, emu);
    sp_dn = confine(sp_q - 1'b1, emu);
    sp_en = load | step;
    if (load)         sp_d = confine(load_value, emu);
    else if (step_up) sp_d = sp_up;
    else              sp_d = sp_dn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= RESET_SP;
    else if (sp_en) sp_q <= sp_d;
  end

  AST_LOAD_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    load && emu |=> sp_q[SP_W-1:LOW_W] == EMU_PAGE); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step |=> $stable(sp_q)); // R6

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 3,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W = 2,
  parameter int unsigned LANE_W = 2,
  parameter int unsigned DATA_W = MAX_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_push,
  input  logic [CNT_W-1:0]  req_size,
  input  logic [DATA_W-1:0] req_data,
  output logic              ready,
  output logic              done,
  output logic              xfer,
  output logic              xfer_push,
  output logic [LANE_W-1:0] lane,
  output logic [BYTE_W-1:0] push_byte,
  output logic              pop_start
);

  stk_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              push_q, push_d;
  logic [DATA_W-1:0] data_q;
  logic              done_q, done_d;
  logic              size_ok;
  logic              accept;

  always_comb begin
    size_ok   = (req_size != '0) && (req_size <= CNT_W'(MAX_BYTES));
    accept    = (state_q == ST_IDLE) && req_valid && size_ok;
    state_d   = state_q;
    cnt_d     = cnt_q;
    lane_d    = lane_q;
    push_d    = push_q;
    done_d    = 1'b0;
    pop_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d   = ST_XFER;
          cnt_d     = req_size;
          push_d    = req_push;
          lane_d    = req_push ? LANE_W'(req_size - 1'b1) : '0;
          pop_start = !req_push;
        end
      end
      ST_XFER: begin
        cnt_d  = cnt_q - 1'b1;
        lane_d = push_q ? lane_q - 1'b1 : lane_q + 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          if (push_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lane_q  <= '0;
      push_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lane_q  <= lane_d;
      push_q  <= push_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (accept) data_q <= req_data;
  end

  assign ready     = (state_q == ST_IDLE);
  assign done      = done_q;
  assign xfer      = (state_q == ST_XFER);
  assign xfer_push = push_q;
  assign lane      = lane_q;
  assign push_byte = data_q[lane_q*BYTE_W +: BYTE_W];

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9

  AST_XFER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_XFER |-> cnt_q != '0); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> state_q == ST_IDLE); // R9

endmodule

// File: rtl/stk_pop_asm.sv
module stk_pop_asm #(
  parameter int unsigned MAX_BYTES = 3,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANE_W = 2,
  parameter int unsigned DATA_W = MAX_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rd_issue,
  input  logic [LANE_W-1:0] rd_lane,
  input  logic [BYTE_W-1:0] rdata,
  output logic [DATA_W-1:0] pop_data
);

  logic              cap_q;
  logic [LANE_W-1:0] cap_lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q      <= 1'b0;
      cap_lane_q <= '0;
    end else begin
      cap_q      <= rd_issue;
      cap_lane_q <= rd_lane;
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] byte_q;
    logic              lane_en;

    assign lane_en = cap_q && (cap_lane_q == LANE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (clear)   byte_q <= '0;
      else if (lane_en) byte_q <= rdata;
    end

    assign pop_data[g*BYTE_W +: BYTE_W] = byte_q;
  end

  AST_CLEAR_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !cap_q); // R5

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int unsigned SP_W = 16,
  parameter int unsigned BANK_W = 8,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned MAX_BYTES = 3,
  parameter logic [SP_W-1:0] RESET_SP = 16'h01FF,
  parameter int unsigned CNT_W = $clog2(MAX_BYTES + 1),
  parameter int unsigned DATA_W = MAX_BYTES * BYTE_W,
  parameter int unsigned ADDR_W = SP_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emu_mode,
  input  logic              load_en,
  input  logic [SP_W-1:0]   load_value,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_push,
  input  logic [CNT_W-1:0]  req_size,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic [DATA_W-1:0] pop_data,
  output logic [SP_W-1:0]   sp,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_rd_en,
  input  logic [BYTE_W-1:0] mem_rdata
);

  localparam int unsigned LOW_W  = 8;
  localparam int unsigned LANE_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam logic [SP_W-LOW_W-1:0] EMU_PAGE = 'h1;

  logic              rst_sync_n;
  logic              xfer;
  logic              xfer_push;
  logic [LANE_W-1:0] lane;
  logic [BYTE_W-1:0] push_byte;
  logic              pop_start;
  logic [SP_W-1:0]   sp_up;
  logic              load_ok;

  stk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stk_seq #(
    .MAX_BYTES (MAX_BYTES),
    .BYTE_W    (BYTE_W),
    .CNT_W     (CNT_W),
    .LANE_W    (LANE_W),
    .DATA_W    (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_push  (req_push),
    .req_size  (req_size),
    .req_data  (req_data),
    .ready     (req_ready),
    .done      (done),
    .xfer      (xfer),
    .xfer_push (xfer_push),
    .lane      (lane),
    .push_byte (push_byte),
    .pop_start (pop_start)
  );

  assign load_ok = load_en && req_ready;

  stk_ptr #(
    .SP_W     (SP_W),
    .LOW_W    (LOW_W),
    .RESET_SP (RESET_SP),
    .EMU_PAGE (EMU_PAGE)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .emu        (emu_mode),
    .load       (load_ok),
    .load_value (load_value),
    .step       (xfer),
    .step_up    (!xfer_push),
    .sp_q       (sp),
    .sp_up      (sp_up)
  );

  stk_pop_asm #(
    .MAX_BYTES (MAX_BYTES),
    .BYTE_W    (BYTE_W),
    .LANE_W    (LANE_W),
    .DATA_W    (DATA_W)
  ) u_asm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (pop_start),
    .rd_issue (mem_rd_en),
    .rd_lane  (lane),
    .rdata    (mem_rdata),
    .pop_data (pop_data)
  );

  assign mem_addr  = {BANK_W'(0), (xfer_push ? sp : sp_up)};
  assign mem_wr_en = xfer && xfer_push;
  assign mem_rd_en = xfer && !xfer_push;
  assign mem_wdata = push_byte;

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_en |=> sp == ($past(emu_mode)
                         ? {EMU_PAGE, LOW_W'($past(mem_addr[LOW_W-1:0]) - 1'b1)}
                         : SP_W'($past(mem_addr[SP_W-1:0]) - 1'b1))); // R1

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_rd_en |=> sp == $past(mem_addr[SP_W-1:0])); // R2

  AST_EMU_PAGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    emu_mode && (mem_wr_en || mem_rd_en) |=> sp[SP_W-1:LOW_W] == EMU_PAGE); // R3

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({mem_wr_en, mem_rd_en})); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_wr_en || mem_rd_en) |-> !req_ready); // R8

endmodule

// File: tb/stack_ptr_unit_bench.sv
`timescale 1ns/1ps
module stack_ptr_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        emu_mode;
  logic        load_en;
  logic [15:0] load_value;
  logic        req_valid;
  logic        req_ready;
  logic        req_push;
  logic [1:0]  req_size;
  logic [23:0] req_data;
  logic        done;
  logic [23:0] pop_data;
  logic [15:0] sp;
  logic [23:0] mem_addr;
  logic        mem_wr_en;
  logic [7:0]  mem_wdata;
  logic        mem_rd_en;
  logic [7:0]  mem_rdata;

  stack_ptr_unit u_stack_ptr_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .emu_mode   (emu_mode),
    .load_en    (load_en),
    .load_value (load_value),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_push   (req_push),
    .req_size   (req_size),
    .req_data   (req_data),
    .done       (done),
    .pop_data   (pop_data),
    .sp         (sp),
    .mem_addr   (mem_addr),
    .mem_wr_en  (mem_wr_en),
    .mem_wdata  (mem_wdata),
    .mem_rd_en  (mem_rd_en),
    .mem_rdata  (mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  mem [0:4095];
  logic [23:0] wlog_a [0:63];
  logic [7:0]  wlog_d [0:63];
  logic [23:0] rlog_a [0:63];
  int          wn = 0;
  int          rn = 0;
  int          both_cnt = 0;

  initial mem_rdata = 8'h00;

  always @(posedge clk) begin
    if (mem_wr_en) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wlog_a[wn % 64]     <= mem_addr;
      wlog_d[wn % 64]     <= mem_wdata;
      wn                  <= wn + 1;
    end
    if (mem_rd_en) begin
      mem_rdata       <= mem[mem_addr[11:0]];
      rlog_a[rn % 64] <= mem_addr;
      rn              <= rn + 1;
    end
    if (mem_wr_en && mem_rd_en) both_cnt <= both_cnt + 1;
  end

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic e, input logic [15:0] v);
    @(negedge clk);
    emu_mode   = e;
    load_en    = 1'b1;
    load_value = v;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_req(input logic p, input logic [1:0] s, input logic [23:0] d, output int lat);
    @(negedge clk);
    req_valid = 1'b1;
    req_push  = p;
    req_size  = s;
    req_data  = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  typedef struct packed {
    logic        emu;
    logic        ld;
    logic [15:0] ldv;
    logic        push;
    logic [1:0]  size;
    logic [23:0] data;
    logic [15:0] esp;
    logic [23:0] epop;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b1, 16'h2000, 1'b1, 2'd3, 24'hA1B2C3, 16'h1FFD, 24'h000000},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 2'd3, 24'h000000, 16'h2000, 24'hA1B2C3},
    '{1'b0, 1'b0, 16'h0000, 1'b1, 2'd2, 24'h005A6B, 16'h1FFE, 24'h000000},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 2'd1, 24'h000000, 16'h1FFF, 24'h00006B},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 2'd1, 24'h000000, 16'h2000, 24'h00005A},
    '{1'b1, 1'b1, 16'h3405, 1'b1, 2'd3, 24'h112233, 16'h0102, 24'h000000},
    '{1'b1, 1'b0, 16'h0000, 1'b0, 2'd2, 24'h000000, 16'h0104, 24'h002233},
    '{1'b1, 1'b1, 16'h0101, 1'b1, 2'd3, 24'h445566, 16'h01FE, 24'h000000},
    '{1'b1, 1'b0, 16'h0000, 1'b0, 2'd3, 24'h000000, 16'h0101, 24'h445566},
    '{1'b0, 1'b1, 16'h0001, 1'b1, 2'd2, 24'h007788, 16'hFFFF, 24'h000000},
    '{1'b0, 1'b0, 16'h0000, 1'b0, 2'd2, 24'h000000, 16'h0001, 24'h007788},
    '{1'b0, 1'b1, 16'hFFFF, 1'b0, 2'd1, 24'h000000, 16'h0000, 24'h000088}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errs++;
      $display("FAIL watchdog R8 actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    int w0;
    int r0;
    int dcnt;
    logic [15:0] sp0;
    rst_n      = 1'b0;
    emu_mode   = 1'b0;
    load_en    = 1'b0;
    load_value = 16'h0000;
    req_valid  = 1'b0;
    req_push   = 1'b0;
    req_size   = 2'd0;
    req_data   = 24'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 sp", 32'(sp), 32'h01FF);
    chk("R10 ready", 32'(req_ready), 32'h1);
    chk("R10 done", 32'(done), 32'h0);
    chk("R10 access", 32'({mem_wr_en, mem_rd_en}), 32'h0);
    chk("R10 pop_data", 32'(pop_data), 32'h0);

    // table walk: R1 R2 R3 R4 R5 R9
    for (int i = 0; i < 12; i++) begin
      vec_t v;
      v = VEC[i];
      if (v.ld) do_load(v.emu, v.ldv);
      else begin
        @(negedge clk);
        emu_mode = v.emu;
      end
      do_req(v.push, v.size, v.data, lat);
      chk($sformatf("R9 latency vec%0d", i), 32'(lat), v.push ? 32'(v.size) + 1 : 32'(v.size) + 2);
      chk($sformatf("R1 R2 R3 sp vec%0d", i), 32'(sp), 32'(v.esp));
      if (!v.push) chk($sformatf("R4 R5 pop_data vec%0d", i), 32'(pop_data), 32'(v.epop));
    end

    // R4 R7 push write order and bank
    do_load(1'b0, 16'h0300);
    w0 = wn;
    do_req(1'b1, 2'd3, 24'hCAFE42, lat);
    chk("R4 write count", 32'(wn - w0), 32'd3);
    chk("R4 R7 addr0", 32'(wlog_a[w0 % 64]), 32'h000300);
    chk("R4 data0 bank", 32'(wlog_d[w0 % 64]), 32'hCA);
    chk("R1 R7 addr1", 32'(wlog_a[(w0 + 1) % 64]), 32'h0002FF);
    chk("R4 data1 high", 32'(wlog_d[(w0 + 1) % 64]), 32'hFE);
    chk("R1 R7 addr2", 32'(wlog_a[(w0 + 2) % 64]), 32'h0002FE);
    chk("R4 data2 low", 32'(wlog_d[(w0 + 2) % 64]), 32'h42);

    // R2 R7 pop read addresses
    r0 = rn;
    do_req(1'b0, 2'd3, 24'h0, lat);
    chk("R2 R7 raddr0", 32'(rlog_a[r0 % 64]), 32'h0002FE);
    chk("R2 R7 raddr1", 32'(rlog_a[(r0 + 1) % 64]), 32'h0002FF);
    chk("R2 R7 raddr2", 32'(rlog_a[(r0 + 2) % 64]), 32'h000300);
    chk("R5 pop assembled", 32'(pop_data), 32'hCAFE42);

    // R8 ready low while busy, R6 load ignored while busy
    do_load(1'b0, 16'h1000);
    @(negedge clk);
    req_valid = 1'b1;
    req_push  = 1'b1;
    req_size  = 2'd3;
    req_data  = 24'h010203;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 ready busy", 32'(req_ready), 32'h0);
    load_en    = 1'b1;
    load_value = 16'h5555;
    @(negedge clk);
    load_en = 1'b0;
    lat = 2;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk("R6 busy load ignored", 32'(sp), 32'h0FFD);
    chk("R5 pop_data held over push", 32'(pop_data), 32'hCAFE42);
    @(negedge clk);
    chk("R9 done single cycle", 32'(done), 32'h0);
    chk("R8 ready after done", 32'(req_ready), 32'h1);

    // R8 size zero ignored
    w0   = wn;
    r0   = rn;
    sp0  = sp;
    dcnt = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_push  = 1'b1;
    req_size  = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (done) dcnt++;
      @(negedge clk);
    end
    chk("R8 size0 writes", 32'(wn - w0), 32'd0);
    chk("R8 size0 reads", 32'(rn - r0), 32'd0);
    chk("R8 size0 done", 32'(dcnt), 32'd0);
    chk("R8 size0 sp", 32'(sp), 32'(sp0));

    // R6 direct loads
    do_load(1'b1, 16'hABCD);
    chk("R6 emu load", 32'(sp), 32'h01CD);
    do_load(1'b0, 16'hABCD);
    chk("R6 native load", 32'(sp), 32'hABCD);

    // R7 never read and write together
    chk("R7 exclusive access", 32'(both_cnt), 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule